// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side serial engine of a small serial flash. It watches the chip-select, serial clock, serial input and pause pins, synchronising each of them into the system clock domain. Input bits are taken on serial-clock rising edges, so both idle-low and idle-high clock polarities with rising-edge sampling work. Every transfer is most significant bit first. The first byte after select is the command. Depending on the command, the block collects a three-byte address and then either receives data bytes or streams bytes out. Outgoing bytes come from the array, from the status register, or from the identification bytes.

Commands that change the array or the status register are not executed here. The block reports them as one-cycle strobes after chip-select is released, but only when the transfer ended on a byte boundary. Program and status-write data bytes go out on a per-byte receive port, each with its target address. Array reads use a synchronous byte port that returns data one clock after the read strobe. The block also handles three lockouts. While an internal write is in progress, everything except a status read is dropped. The pause pin suspends shifting. An unknown command silences the block for the rest of the selection.

Top module: `spi_flash_front`

## Requirements
- R1: The command byte is decoded with bit 3 ignored: 0000x110 write-enable, 0000x100 write-disable, 0000x101 status read, 0000x001 status write, 0000x011 array read, 0000x010 program, 0101x010 sector erase, 0110x010 chip erase, 0001x101 identification read.
- R2: Any other command byte locks the block for the rest of the selection: no strobe, no receive pulse, and the output stays undriven. The next selection decodes normally.
- R3: An array read takes three address bytes, most significant first, and keeps only the low ADDR_W bits. It then streams one byte per eight clocks, most significant bit first. The address increments after each byte and wraps from the top address to 0. The output bit changes only after a serial-clock falling edge.
- R4: A status read streams the status_byte input, reloading it at every byte boundary.
- R5: An identification read returns 0x1F, then DEV_CODE, then 0x00 for every later byte.
- R6: While busy is high at the end of the command byte, every command other than status read is dropped as in R2. Status read still works.
- R7: A low hold_n is recognised only while the serial clock is low. While paused, serial-clock edges and input bits are ignored and the output is undriven. Releasing hold_n while the clock is low resumes the transfer where it stopped.
- R8: While chip-select is high, the output is undriven and clock and input activity has no effect on the next transfer.
- R9: The strobes work as follows. Write-enable, write-disable and chip erase each need only the command byte. Sector erase needs three address bytes. Status write needs one data byte. Each strobe is a single one-cycle pulse after chip-select rises, and only when no partial byte was clocked.
- R10: Each program data byte gives a one-cycle rx_valid with rx_byte and rx_addr. The address steps within a page of 2^PAGE_W bytes and wraps to the start of that page. cmd_program pulses only if at least one data byte arrived.
- R11: Both clock polarities (idle low and idle high) give the same results.
- R12: After reset the output is undriven and no strobe, receive pulse or memory read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for so; low means high impedance |
| busy | input | 1 | Internal write cycle in progress |
| status_byte | input | 8 | Status register value to send |
| mem_rd_en | output | 1 | Array read strobe |
| mem_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array byte, valid one clock after mem_rd_en |
| rx_valid | output | 1 | Received data byte pulse |
| rx_byte | output | 8 | Received data byte |
| rx_addr | output | ADDR_W | Target address of the received byte |
| cmd_wren | output | 1 | Write-enable strobe |
| cmd_wrdi | output | 1 | Write-disable strobe |
| cmd_wrsr | output | 1 | Status-write strobe |
| cmd_program | output | 1 | Program strobe |
| cmd_erase_sector | output | 1 | Sector-erase strobe |
| cmd_erase_chip | output | 1 | Chip-erase strobe |

## Verification
The bench targets the places where the byte count and bit count must stay in step. A read that starts two bytes below the top address must continue at 0; a design that carries the address into bits it ignores would return wrong bytes. A program run that crosses the page end must return to the page start instead of moving to the next page. A pause in the middle of a data byte, with the clock still toggling, must resume on the same bit; a design that counts clock edges while paused would shift the rest of the stream. A transfer that ends with a few stray bits, a command given while busy, and an unknown command followed by a valid one must each produce no strobe. A design that is loose about byte alignment or lockout would start a write that was never requested.

// File: rtl/sff_pkg.sv
// Shared types and the command decoder of the serial flash front-end.
// Assumes an 8-bit command byte in which bit 3 carries no meaning.
package sff_pkg;

    typedef enum logic [3:0] {
        OP_BAD, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR,
        OP_READ, OP_PROG, OP_SERASE, OP_CERASE, OP_RDID
    } op_e;

    typedef enum logic [2:0] {
        S_OPC,   // collecting the command byte
        S_ADDR,  // collecting address bytes
        S_WIN,   // receiving data bytes
        S_ROUT,  // sending bytes
        S_SKIP   // ignoring the rest of the selection
    } st_e;

    localparam logic [7:0] MFR_CODE = 8'h1F;

    // Map a received command byte to an operation; bit 3 is a wildcard.
    function automatic op_e decode_op(input logic [7:0] b);
        op_e r;
        casez (b)
            8'b0000?110: r = OP_WREN;
            8'b0000?100: r = OP_WRDI;
            8'b0000?101: r = OP_RDSR;
            8'b0000?001: r = OP_WRSR;
            8'b0000?011: r = OP_READ;
            8'b0000?010: r = OP_PROG;
            8'b0101?010: r = OP_SERASE;
            8'b0110?010: r = OP_CERASE;
            8'b0001?101: r = OP_RDID;
            default:     r = OP_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sff_pin_cond.sv
// Pin conditioning: synchronises the four serial pins into clk, detects
// clock and select edges, and tracks the pause state. Assumes each serial
// clock phase lasts at least four clk cycles. A pause is taken or released
// only while the synchronised serial clock is low.
module sff_pin_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic sel,
    output logic cs_rise,
    output logic rise_ev,
    output logic fall_ev,
    output logic si_s,
    output logic hold_act
);
    localparam int NPIN = 4;
    localparam logic [NPIN-1:0] IDLE = 4'b1001; // hold_n, si, sck, cs_n

    logic [NPIN-1:0] raw;
    logic [SYNC_STAGES-1:0][NPIN-1:0] stage;
    logic [NPIN-1:0] synced;
    logic cs_s, sck_s, hold_s, cs_q, sck_q;

    assign raw    = {hold_n, si, sck, cs_n};
    assign synced = stage[SYNC_STAGES-1];
    assign cs_s   = synced[0];
    assign sck_s  = synced[1];
    assign si_s   = synced[2];
    assign hold_s = synced[3];

    // Synchroniser chain for all pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= {SYNC_STAGES{IDLE}};
        else        stage <= {stage[SYNC_STAGES-2:0], raw};
    end

    // Previous-value registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;
        end
    end

    // Pause state, updated only while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_act <= 1'b0;
        else if (cs_s)   hold_act <= 1'b0;
        else if (!sck_s) hold_act <= !hold_s;
    end

    assign sel     = !cs_s;
    assign cs_rise = cs_s && !cs_q;
    assign rise_ev = sel && !hold_act && sck_s && !sck_q;
    assign fall_ev = sel && !hold_act && !sck_s && sck_q;

endmodule

// File: rtl/sff_cmd_engine.sv
// Command engine: shifts bytes in, decodes the command, gathers the
// address, streams bytes out and issues strobes at deselect. Assumes
// events from sff_pin_cond are at least four clk cycles apart, that the
// array answers one clk after mem_rd_en, and 8 < ADDR_W <= 24.
module sff_cmd_engine
    import sff_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter int         PAGE_W   = 8,
    parameter logic [7:0] DEV_CODE = 8'h65
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cs_rise,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              si_s,
    input  logic              hold_act,
    input  logic              busy,
    input  logic [7:0]        status_byte,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              so,
    output logic              so_oe,
    output logic              rx_valid,
    output logic [7:0]        rx_byte,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              cmd_wren,
    output logic              cmd_wrdi,
    output logic              cmd_wrsr,
    output logic              cmd_program,
    output logic              cmd_erase_sector,
    output logic              cmd_erase_chip
);
    localparam logic [ADDR_W-1:0] A_ONE = 1;
    localparam logic [PAGE_W-1:0] P_ONE = 1;

    logic [2:0]        bit_cnt;
    logic [6:0]        shreg;
    logic [7:0]        nb;
    logic              byte_done;
    st_e               state;
    op_e               op, arm, dec;
    logic [1:0]        abyte;
    logic [ADDR_W-1:0] addr, addr_page_nx;
    logic              reload, reload_q;
    logic [1:0]        id_idx;
    logic [7:0]        tx;
    logic              so_bit, out_live;

    assign nb           = {shreg, si_s};
    assign byte_done    = rise_ev && (bit_cnt == 3'd7);
    assign dec          = decode_op(nb);
    assign addr_page_nx = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + P_ONE};
    assign mem_addr     = addr;

    // Input shift register and bit counter; cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= 3'd0;
            shreg   <= 7'd0;
        end else if (!sel) begin
            bit_cnt <= 3'd0;
        end else if (rise_ev) begin
            shreg   <= nb[6:0];
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    // Byte-level sequencer: command, address, data in, data out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_OPC;
            op        <= OP_BAD;
            arm       <= OP_BAD;
            abyte     <= 2'd0;
            addr      <= '0;
            reload    <= 1'b0;
            mem_rd_en <= 1'b0;
            rx_valid  <= 1'b0;
            rx_byte   <= 8'd0;
            rx_addr   <= '0;
        end else begin
            reload    <= 1'b0;
            mem_rd_en <= 1'b0;
            rx_valid  <= 1'b0;
            if (!sel) begin
                state <= S_OPC;
                op    <= OP_BAD;
                arm   <= OP_BAD;
                abyte <= 2'd0;
            end else begin
                if (reload_q && op == OP_READ) addr <= addr + A_ONE;
                if (byte_done) begin
                    case (state)
                        S_OPC: begin
                            op <= dec;
                            if (dec == OP_BAD || (busy && dec != OP_RDSR)) begin
                                state <= S_SKIP;
                                op    <= OP_BAD;
                            end else begin
                                case (dec)
                                    OP_WREN, OP_WRDI, OP_CERASE: begin
                                        state <= S_SKIP;
                                        arm   <= dec;
                                    end
                                    OP_RDSR, OP_RDID: begin
                                        state  <= S_ROUT;
                                        reload <= 1'b1;
                                    end
                                    OP_WRSR: state <= S_WIN;
                                    default: state <= S_ADDR;
                                endcase
                            end
                        end
                        S_ADDR: begin
                            addr  <= {addr[ADDR_W-9:0], nb};
                            abyte <= abyte + 2'd1;
                            if (abyte == 2'd2) begin
                                case (op)
                                    OP_READ: begin
                                        state     <= S_ROUT;
                                        mem_rd_en <= 1'b1;
                                        reload    <= 1'b1;
                                    end
                                    OP_PROG: state <= S_WIN;
                                    default: begin
                                        state <= S_SKIP;
                                        arm   <= op;
                                    end
                                endcase
                            end
                        end
                        S_WIN: begin
                            rx_valid <= 1'b1;
                            rx_byte  <= nb;
                            rx_addr  <= addr;
                            arm      <= op;
                            if (op == OP_PROG) addr  <= addr_page_nx;
                            else               state <= S_SKIP;
                        end
                        S_ROUT: begin
                            reload <= 1'b1;
                            if (op == OP_READ) mem_rd_en <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Output byte loading and falling-edge bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= 1'b0;
            tx       <= 8'd0;
            so_bit   <= 1'b0;
            out_live <= 1'b0;
            id_idx   <= 2'd0;
        end else begin
            reload_q <= reload;
            if (!sel) begin
                out_live <= 1'b0;
                id_idx   <= 2'd0;
            end else if (reload_q) begin
                case (op)
                    OP_READ: tx <= mem_rd_data;
                    OP_RDSR: tx <= status_byte;
                    OP_RDID: tx <= (id_idx == 2'd0) ? MFR_CODE :
                                   (id_idx == 2'd1) ? DEV_CODE : 8'h00;
                    default: tx <= 8'h00;
                endcase
                if (op == OP_RDID && id_idx != 2'd2) id_idx <= id_idx + 2'd1;
            end else if (fall_ev && state == S_ROUT) begin
                so_bit   <= tx[7];
                tx       <= {tx[6:0], 1'b0};
                out_live <= 1'b1;
            end
        end
    end

    // Command strobes, one cycle after deselect, byte-aligned only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_program, cmd_erase_sector, cmd_erase_chip} <= 6'd0;
        end else begin
            {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_program, cmd_erase_sector, cmd_erase_chip} <= 6'd0;
            if (cs_rise && bit_cnt == 3'd0) begin
                case (arm)
                    OP_WREN:   cmd_wren         <= 1'b1;
                    OP_WRDI:   cmd_wrdi         <= 1'b1;
                    OP_WRSR:   cmd_wrsr         <= 1'b1;
                    OP_PROG:   cmd_program      <= 1'b1;
                    OP_SERASE: cmd_erase_sector <= 1'b1;
                    OP_CERASE: cmd_erase_chip   <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign so    = so_bit;
    assign so_oe = sel && !hold_act && (state == S_ROUT) && out_live;

endmodule

// File: rtl/spi_flash_front.sv
// Top of the serial flash command front-end: pin conditioning followed by
// the command engine. Assumes clk runs at least eight times the serial
// clock rate.
module spi_flash_front #(
    parameter int         ADDR_W      = 17,
    parameter int         PAGE_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DEV_CODE    = 8'h65
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    input  logic              busy,
    input  logic [7:0]        status_byte,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              rx_valid,
    output logic [7:0]        rx_byte,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              cmd_wren,
    output logic              cmd_wrdi,
    output logic              cmd_wrsr,
    output logic              cmd_program,
    output logic              cmd_erase_sector,
    output logic              cmd_erase_chip
);
    logic sel, cs_rise, rise_ev, fall_ev, si_s, hold_act;

    sff_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .sel(sel), .cs_rise(cs_rise), .rise_ev(rise_ev),
        .fall_ev(fall_ev), .si_s(si_s), .hold_act(hold_act)
    );

    sff_cmd_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_CODE(DEV_CODE)) u_eng (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cs_rise(cs_rise),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .si_s(si_s), .hold_act(hold_act),
        .busy(busy), .status_byte(status_byte), .mem_rd_data(mem_rd_data),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .so(so), .so_oe(so_oe),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_addr(rx_addr),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_program(cmd_program), .cmd_erase_sector(cmd_erase_sector),
        .cmd_erase_chip(cmd_erase_chip)
    );

endmodule

// File: rtl/sff_checker.sv
// Property checker for spi_flash_front, attached by bind below. Tracks the
// previous read and receive addresses within one selection.
module sff_checker #(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              fall_ev,
    input logic              so,
    input logic              so_oe,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rx_valid,
    input logic [ADDR_W-1:0] rx_addr,
    input logic [5:0]        cmds
);
    localparam logic [ADDR_W-1:0] A_ONE = 1;
    localparam logic [PAGE_W-1:0] P_ONE = 1;

    logic              have_rd, have_rx;
    logic [ADDR_W-1:0] last_rd, last_rx;

    // Remember the last read and receive addresses of this selection.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            have_rd <= 1'b0;
            have_rx <= 1'b0;
            last_rd <= '0;
            last_rx <= '0;
        end else begin
            if (mem_rd_en) begin
                have_rd <= 1'b1;
                last_rd <= mem_addr;
            end
            if (rx_valid) begin
                have_rx <= 1'b1;
                last_rx <= rx_addr;
            end
        end
    end

    // R9: at most one strobe at a time
    a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmds));

    // R9: strobes last a single cycle
    a_r9_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmds != 6'd0) |=> (cmds == 6'd0));

    // R9: strobes appear only once deselected
    a_r9_strobe_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cmds != 6'd0) |-> !sel);

    // R3: consecutive array reads step the address by one, wrapping
    a_r3_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && have_rd) |-> (mem_addr == last_rd + A_ONE));

    // R10: consecutive program bytes step within the page
    a_r10_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && have_rx) |->
        (rx_addr == {last_rx[ADDR_W-1:PAGE_W], last_rx[PAGE_W-1:0] + P_ONE}));

    // R3: a driven output bit only changes after a clock falling edge
    a_r3_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so != $past(so))) |-> $past(fall_ev));

endmodule

bind spi_flash_front sff_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .fall_ev(fall_ev), .so(so),
    .so_oe(so_oe), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .rx_valid(rx_valid), .rx_addr(rx_addr),
    .cmds({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_program, cmd_erase_sector, cmd_erase_chip})
);

// File: tb/test_spi_flash_front.sv
// Directed bench for spi_flash_front: acts as the serial master, models the
// array, and counts strobes and received bytes.
module test_spi_flash_front;
    localparam int ADDR_W = 17;
    localparam int PAGE_W = 8;
    localparam logic [7:0] DEV = 8'h65;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
    logic [7:0] status_byte = 8'h00, mem_rd_data = 8'h00;
    logic so, so_oe, mem_rd_en, rx_valid;
    logic [ADDR_W-1:0] mem_addr, rx_addr;
    logic [7:0] rx_byte;
    logic cmd_wren, cmd_wrdi, cmd_wrsr, cmd_program, cmd_erase_sector, cmd_erase_chip;

    int vectors = 0, errors = 0;
    logic mode3 = 1'b0;
    logic done = 1'b0;
    int n_wren, n_wrdi, n_wrsr, n_prog, n_sect, n_chip, n_rx;
    logic [7:0] rxb [0:15];
    logic [ADDR_W-1:0] rxa [0:15];

    spi_flash_front #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_CODE(DEV)) i_spi_flash_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .busy(busy), .status_byte(status_byte),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_addr(rx_addr),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_program(cmd_program), .cmd_erase_sector(cmd_erase_sector),
        .cmd_erase_chip(cmd_erase_chip)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ {a[15:8]} ^ {a[16], 7'h35};
    endfunction

    // Array model with one clock of read latency.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_val(mem_addr);

    // Strobe and receive monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_wren += int'(cmd_wren);
            n_wrdi += int'(cmd_wrdi);
            n_wrsr += int'(cmd_wrsr);
            n_prog += int'(cmd_program);
            n_sect += int'(cmd_erase_sector);
            n_chip += int'(cmd_erase_chip);
            if (rx_valid) begin
                if (n_rx < 16) begin
                    rxb[n_rx] = rx_byte;
                    rxa[n_rx] = rx_addr;
                end
                n_rx++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_wren = 0; n_wrdi = 0; n_wrsr = 0; n_prog = 0; n_sect = 0; n_chip = 0; n_rx = 0;
    endtask

    task automatic start();
        sck = mode3;
        tick(4);
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic stop();
        if (!mode3) begin
            sck = 1'b0;
            tick(HALF);
        end
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic bit_io(input logic b, output logic o, output logic oe);
        sck = 1'b0;
        si = b;
        tick(HALF);
        o = so;
        oe = so_oe;
        sck = 1'b1;
        tick(HALF);
    endtask

    task automatic xfer(input logic [7:0] t, output logic [7:0] r,
                        output logic any_oe, output logic all_oe);
        logic o, oe;
        any_oe = 1'b0;
        all_oe = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_io(t[i], o, oe);
            r[i] = o;
            any_oe |= oe;
            all_oe &= oe;
        end
    endtask

    task automatic send(input logic [7:0] t);
        logic [7:0] r;
        logic a, b;
        xfer(t, r, a, b);
    endtask

    task automatic check_strobes(input string req, input int w, input int d,
                                 input int s, input int p, input int e, input int c);
        check(n_wren == w, req, "wren count", n_wren, w);
        check(n_wrdi == d, req, "wrdi count", n_wrdi, d);
        check(n_wrsr == s, req, "wrsr count", n_wrsr, s);
        check(n_prog == p, req, "program count", n_prog, p);
        check(n_sect == e, req, "sector erase count", n_sect, e);
        check(n_chip == c, req, "chip erase count", n_chip, c);
    endtask

    // R12: quiet outputs after reset
    task automatic t_reset();
        check(so_oe == 1'b0, "R12", "so_oe after reset", so_oe, 0);
        check(mem_rd_en == 1'b0, "R12", "mem_rd_en after reset", mem_rd_en, 0);
        check(rx_valid == 1'b0, "R12", "rx_valid after reset", rx_valid, 0);
        check_strobes("R12", 0, 0, 0, 0, 0, 0);
    endtask

    // R1 R9: single-byte commands, with and without the wildcard bit set
    task automatic t_simple_cmds();
        logic [7:0] codes [6] = '{8'h06, 8'h0E, 8'h04, 8'h0C, 8'h62, 8'h6A};
        for (int k = 0; k < 6; k++) begin
            clr_mon(); start(); send(codes[k]); stop();
            check_strobes("R1", (k < 2) ? 1 : 0, (k == 2 || k == 3) ? 1 : 0,
                          0, 0, 0, (k >= 4) ? 1 : 0);
        end
    endtask

    // R4: status stream
    task automatic t_rdsr();
        logic [7:0] r;
        logic a, b;
        status_byte = 8'hA5;
        start();
        xfer(8'h05, r, a, b);
        check(a == 1'b0, "R4", "so_oe during command", a, 0);
        for (int k = 0; k < 2; k++) begin
            xfer(8'h00, r, a, b);
            check(r == 8'hA5, "R4", "status byte", r, 8'hA5);
            check(b == 1'b1, "R4", "so_oe during status", b, 1);
        end
        stop();
        check(so_oe == 1'b0, "R8", "so_oe after deselect", so_oe, 0);
    endtask

    // R5: identification bytes
    task automatic t_rdid();
        logic [7:0] r;
        logic [7:0] exp [3] = '{8'h1F, DEV, 8'h00};
        logic a, b;
        start();
        send(8'h1D);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, r, a, b);
            check(r == exp[k], "R5", "id byte", r, exp[k]);
        end
        stop();
    endtask

    // R3 R11: array read from a 24-bit address with n bytes
    task automatic t_read(input logic [23:0] a24, input int n, input string req);
        logic [7:0] r;
        logic a, b;
        logic [ADDR_W-1:0] ad;
        ad = a24[ADDR_W-1:0];
        start();
        send(8'h03);
        send(a24[23:16]); send(a24[15:8]); send(a24[7:0]);
        for (int k = 0; k < n; k++) begin
            xfer(8'hFF, r, a, b);
            check(r == mem_val(ad), req, "read byte", r, mem_val(ad));
            check(b == 1'b1, req, "so_oe during read", b, 1);
            ad = ad + 1'b1;
        end
        stop();
    endtask

    // R2: unknown command locks the selection; next selection works
    task automatic t_invalid();
        logic [7:0] r;
        logic a, b, seen;
        seen = 1'b0;
        status_byte = 8'h3C;
        clr_mon(); start();
        xfer(8'h07, r, a, b); seen |= a;
        xfer(8'h06, r, a, b); seen |= a;
        xfer(8'h05, r, a, b); seen |= a;
        xfer(8'h00, r, a, b); seen |= a;
        stop();
        check(seen == 1'b0, "R2", "so_oe after bad command", seen, 0);
        check_strobes("R2", 0, 0, 0, 0, 0, 0);
        start(); send(8'h05); xfer(8'h00, r, a, b); stop();
        check(r == 8'h3C, "R2", "status after lockout", r, 8'h3C);
    endtask

    // R6: busy drops all but status read
    task automatic t_busy();
        logic [7:0] r;
        logic a, b, seen;
        busy = 1'b1;
        status_byte = 8'hFF;
        clr_mon();
        start(); send(8'h06); stop();
        start(); send(8'h02); send(8'h00); send(8'h00); send(8'h10); send(8'h11); stop();
        check_strobes("R6", 0, 0, 0, 0, 0, 0);
        check(n_rx == 0, "R6", "rx bytes while busy", n_rx, 0);
        seen = 1'b0;
        start(); send(8'h03); send(8'h00); send(8'h00); send(8'h10);
        xfer(8'h00, r, a, b); seen |= a;
        stop();
        check(seen == 1'b0, "R6", "so_oe on read while busy", seen, 0);
        start(); send(8'h05); xfer(8'h00, r, a, b); stop();
        check(r == 8'hFF, "R6", "status while busy", r, 8'hFF);
        busy = 1'b0;
    endtask

    // R7: pause in the middle of a read byte
    task automatic t_hold();
        logic [7:0] r;
        logic o, oe, seen, a, b;
        logic [ADDR_W-1:0] ad;
        ad = 17'h00456;
        seen = 1'b0;
        start();
        send(8'h03); send(8'h00); send(8'h04); send(8'h56);
        for (int i = 7; i >= 4; i--) begin
            bit_io(1'b0, o, oe);
            r[i] = o;
        end
        sck = 1'b0; tick(HALF);
        hold_n = 1'b0; tick(HALF);
        for (int k = 0; k < 6; k++) begin
            sck = 1'b1; si = k[0]; tick(HALF);
            seen |= so_oe;
            sck = 1'b0; tick(HALF);
            seen |= so_oe;
        end
        hold_n = 1'b1; tick(HALF);
        for (int i = 3; i >= 0; i--) begin
            bit_io(1'b1, o, oe);
            r[i] = o;
        end
        check(seen == 1'b0, "R7", "so_oe while paused", seen, 0);
        check(r == mem_val(ad), "R7", "byte across pause", r, mem_val(ad));
        xfer(8'h00, r, a, b);
        check(r == mem_val(ad + 1'b1), "R7", "byte after pause", r, mem_val(ad + 1'b1));
        stop();
    endtask

    // R8: activity while deselected has no effect
    task automatic t_cs_idle();
        logic [7:0] r;
        logic a, b, seen;
        seen = 1'b0;
        status_byte = 8'h81;
        clr_mon();
        for (int k = 0; k < 16; k++) begin
            sck = 1'b0; si = k[1]; tick(HALF); seen |= so_oe;
            sck = 1'b1; tick(HALF); seen |= so_oe;
        end
        sck = 1'b0; tick(HALF);
        check(seen == 1'b0, "R8", "so_oe while deselected", seen, 0);
        check_strobes("R8", 0, 0, 0, 0, 0, 0);
        start(); send(8'h05); xfer(8'h00, r, a, b); stop();
        check(r == 8'h81, "R8", "status after idle clocks", r, 8'h81);
    endtask

    // R9 R10: address/data commands and byte alignment
    task automatic t_writes();
        logic o, oe;
        clr_mon(); start(); send(8'h52); send(8'h01); send(8'h80); send(8'h00); stop();
        check_strobes("R9", 0, 0, 0, 0, 1, 0);
        clr_mon(); start(); send(8'h52); send(8'h01); send(8'h80); stop();
        check_strobes("R9", 0, 0, 0, 0, 0, 0);
        clr_mon(); start(); send(8'h01); send(8'h8C); stop();
        check_strobes("R9", 0, 0, 1, 0, 0, 0);
        check(n_rx == 1 && rxb[0] == 8'h8C, "R9", "status write data", rxb[0], 8'h8C);
        clr_mon(); start(); send(8'h06);
        for (int k = 0; k < 3; k++) bit_io(1'b1, o, oe);
        stop();
        check(n_wren == 0, "R9", "wren after partial byte", n_wren, 0);
        clr_mon(); start(); send(8'h02); send(8'h00); send(8'h03); send(8'hFE);
        send(8'h11); send(8'h22); send(8'h33);
        stop();
        check(n_prog == 1, "R10", "program strobe", n_prog, 1);
        check(n_rx == 3, "R10", "rx count", n_rx, 3);
        check(rxa[0] == 17'h003FE && rxb[0] == 8'h11, "R10", "rx0 addr", rxa[0], 17'h003FE);
        check(rxa[1] == 17'h003FF && rxb[1] == 8'h22, "R10", "rx1 addr", rxa[1], 17'h003FF);
        check(rxa[2] == 17'h00300 && rxb[2] == 8'h33, "R10", "rx2 page wrap", rxa[2], 17'h00300);
        clr_mon(); start(); send(8'h0A); send(8'h00); send(8'h00); send(8'h10); stop();
        check(n_prog == 0, "R10", "program without data", n_prog, 0);
    endtask

    initial begin
        clr_mon();
        tick(5);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_simple_cmds();
        t_rdsr();
        t_rdid();
        t_read(24'hFE1234, 3, "R3");
        t_read(24'h01FFFE, 3, "R3");
        mode3 = 1'b1;
        t_read(24'h000ABC, 2, "R11");
        t_rdsr();
        t_writes();
        mode3 = 1'b0;
        t_invalid();
        t_busy();
        t_hold();
        t_cs_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule